// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block gathers single-cycle event pulses from a number of functional groups and turns them into one active-low interrupt request for a host. Each event latches a secondary status bit. Each secondary bit has its own mask bit, and the unmasked bits of a group are ORed into one primary status bit per group. Each primary bit also has its own mask bit, and the unmasked primary bits decide whether the interrupt output is asserted.

A host reaches every register through a small single-cycle register bus. It reads the latched secondary bits and clears them by writing ones. It programs the two mask levels, reads the primary status, and sets a configuration register. That register selects push-pull or open-drain signalling and can suppress the output as a whole. The output pin is modelled as a data bit plus an output enable. Its level is registered, so it follows a status change one clock later.

Parameters: `NGRP` groups (default 4) of `NSEC` secondary bits each (default 8, and `NSEC >= NGRP`). The bus data width is `NSEC`. Register addresses are: secondary status of group g at g; secondary mask of group g at `NGRP+g`; primary status at `2*NGRP`; primary mask at `2*NGRP+1`; configuration at `2*NGRP+2`. Unmapped addresses read 0.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on `evt[g*NSEC+b]` sets bit b of the secondary status register of group g at the next clock edge. The bit then stays at 1 with no further events.
- R2: Writing a word to the status address of group g clears each bit written as 1 and leaves bits written as 0 unchanged. Reading a status register never changes it.
- R3: If an event and a write-one-to-clear reach the same bit in the same cycle, the bit is 1 afterwards.
- R4: A secondary bit latches in the same way when its mask bit is 1 (1 = masked).
- R5: Bit g of the primary status register is the OR of the group-g secondary bits whose mask bit is 0. It returns to 0 once those bits are cleared.
- R6: A write to the primary status address has no effect on any register or on the output.
- R7: Configuration bit 1 selects the output mode; 0 is push-pull. In push-pull mode `irq_oe` is 1. `irq_o` is 0 while any primary bit whose primary mask bit is 0 is set, and 1 otherwise. The output changes one cycle after the status that causes it.
- R8: A primary bit updates from its unmasked secondary bits whatever its own primary mask bit holds.
- R9: In open-drain mode (configuration bit 1 = 1) the output drives `irq_oe`=1 with `irq_o`=0 when asserted, and `irq_oe`=0 when not asserted.
- R10: While configuration bit 0 (global mask) is 1, the output is inactive: high in push-pull mode, released in open-drain mode. Status registers still latch.
- R11: After reset all status bits are 0, all mask bits are 1, configuration is 0, and the output drives high (`irq_oe`=1, `irq_o`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NGRP*NSEC | Event pulses, one per secondary bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | $clog2(2*NGRP+3) | Register address |
| wdata | input | NSEC | Write data |
| rdata | output | NSEC | Read data for `addr` (combinational) |
| irq_o | output | 1 | Interrupt pin data, active low |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume an event bit and a clear of that bit may meet in one cycle. They also assume register writes are single-cycle strobes with a stable address. No other bus protocol is involved. The properties on hold and clear compare state across one edge only, so any sequence of events and writes is legal. The directed stimulus changes inputs only on the falling edge and holds each write for exactly one rising edge. This keeps it inside those assumptions while still producing the event-versus-clear collision on purpose.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NGRP = 4,
  parameter int NSEC = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NGRP*NSEC-1:0]         evt,
  input  logic                         wr_en,
  input  logic [$clog2(2*NGRP+3)-1:0]  addr,
  input  logic [NSEC-1:0]              wdata,
  output logic [NSEC-1:0]              rdata,
  output logic                         irq_o,
  output logic                         irq_oe
);
  localparam int NBIT     = NGRP * NSEC;
  localparam int AW       = $clog2(2*NGRP+3);
  localparam int A_PRIM   = 2*NGRP;
  localparam int A_PMASK  = 2*NGRP + 1;
  localparam int A_CFG    = 2*NGRP + 2;

  logic [NBIT-1:0] sec_q, smask_q;
  logic [NGRP-1:0] prim, pmask_q;
  logic            od_q, gmask_q, pend;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic clr_hit, msk_hit;
    assign clr_hit = wr_en && (addr == AW'(g));
    assign msk_hit = wr_en && (addr == AW'(NGRP + g));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sec_q[g*NSEC +: NSEC]   <= '0;
        smask_q[g*NSEC +: NSEC] <= '1;
      end else begin
        sec_q[g*NSEC +: NSEC] <= (sec_q[g*NSEC +: NSEC] & ~(clr_hit ? wdata : '0))
                                 | evt[g*NSEC +: NSEC];
        if (msk_hit) smask_q[g*NSEC +: NSEC] <= wdata;
      end

    assign prim[g] = |(sec_q[g*NSEC +: NSEC] & ~smask_q[g*NSEC +: NSEC]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pmask_q <= '1;
      od_q    <= 1'b0;
      gmask_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == AW'(A_PMASK)) pmask_q <= wdata[NGRP-1:0];
      if (addr == AW'(A_CFG)) begin
        gmask_q <= wdata[0];
        od_q    <= wdata[1];
      end
    end

  assign pend = |(prim & ~pmask_q) & ~gmask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_oe <= 1'b1;
      irq_o  <= 1'b1;
    end else begin
      irq_oe <= ~od_q | pend;
      irq_o  <= ~od_q & ~pend;
    end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (addr == AW'(g))        rdata = sec_q[g*NSEC +: NSEC];
      if (addr == AW'(NGRP + g)) rdata = smask_q[g*NSEC +: NSEC];
    end
    if (addr == AW'(A_PRIM))  rdata = NSEC'(prim);
    if (addr == AW'(A_PMASK)) rdata = NSEC'(pmask_q);
    if (addr == AW'(A_CFG))   rdata = NSEC'({od_q, gmask_q});
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NGRP = 4,
  parameter int NSEC = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NGRP*NSEC-1:0]        evt,
  input logic                        wr_en,
  input logic [$clog2(2*NGRP+3)-1:0] addr,
  input logic [NGRP*NSEC-1:0]        sec_q,
  input logic [NGRP-1:0]             prim,
  input logic [NGRP-1:0]             pmask_q,
  input logic                        od_q,
  input logic                        gmask_q,
  input logic                        irq_o,
  input logic                        irq_oe
);
  assert_evt_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sec_q & $past(evt)) == $past(evt)));

  assert_hold_without_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && int'(addr) < NGRP) |=> ((sec_q & $past(sec_q)) == $past(sec_q)));

  assert_prim_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q == '0) |-> (prim == '0));

  assert_pending_drives_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(prim & ~pmask_q)) && !gmask_q) |=> (irq_oe && !irq_o));

  assert_od_never_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(od_q) && irq_oe) |-> !irq_o);

  assert_gmask_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |=> (irq_o || !irq_oe));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NGRP(NGRP), .NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .addr(addr),
  .sec_q(sec_q), .prim(prim), .pmask_q(pmask_q), .od_q(od_q),
  .gmask_q(gmask_q), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam int NGRP = 4;
  localparam int NSEC = 8;
  localparam int AW   = $clog2(2*NGRP+3);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NGRP*NSEC-1:0] evt = '0;
  logic [AW-1:0] addr = '0;
  logic [NSEC-1:0] wdata = '0, rdata;
  logic irq_o, irq_oe;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NGRP(NGRP), .NSEC(NSEC)) uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_oe(irq_oe));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [NSEC-1:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [NSEC-1:0] d);
    addr = AW'(a); #1 d = rdata;
  endtask

  task automatic pulse(int bitn);
    @(negedge clk); evt = '0; evt[bitn] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd_chk(string tag, int a, logic [NSEC-1:0] exp);
    logic [NSEC-1:0] d;
    rd(a, d); check(tag, d, exp);
  endtask

  task automatic pin_chk(string tag, logic oe, logic o);
    check(tag, {irq_oe, irq_o}, {oe, o});
  endtask

  task automatic t_reset;
    for (int g = 0; g < NGRP; g++) begin
      rd_chk("R11 sec", g, 8'h00);
      rd_chk("R11 smask", NGRP + g, 8'hFF);
    end
    rd_chk("R11 prim", 2*NGRP, 8'h00);
    rd_chk("R11 pmask", 2*NGRP + 1, 8'h0F);
    rd_chk("R11 cfg", 2*NGRP + 2, 8'h00);
    pin_chk("R11 pin", 1, 1);
  endtask

  task automatic t_latch;
    wr(NGRP + 1, 8'hF7);
    wr(2*NGRP + 1, 8'h0D);
    pulse(1*NSEC + 3);
    rd_chk("R1 latched", 1, 8'h08);
    pin_chk("R7 not yet", 1, 1);
    tick();
    pin_chk("R7 asserted", 1, 0);
    rd_chk("R5 prim", 2*NGRP, 8'h02);
    tick(5);
    rd_chk("R1 held", 1, 8'h08);
  endtask

  task automatic t_w1c;
    rd_chk("R2 read1", 1, 8'h08);
    rd_chk("R2 read2", 1, 8'h08);
    wr(1, 8'hF7);
    rd_chk("R2 zeros keep", 1, 8'h08);
    wr(1, 8'h08);
    rd_chk("R2 cleared", 1, 8'h00);
    rd_chk("R5 prim clears", 2*NGRP, 8'h00);
    tick();
    pin_chk("R7 deasserted", 1, 1);
  endtask

  task automatic t_masked;
    pulse(2*NSEC);
    rd_chk("R4 masked latch", 2, 8'h01);
    rd_chk("R4 prim stays 0", 2*NGRP, 8'h00);
    tick(2);
    pin_chk("R4 pin idle", 1, 1);
    wr(2, 8'h01);
    rd_chk("R4 clear", 2, 8'h00);
  endtask

  task automatic t_pmask;
    wr(NGRP + 2, 8'hFE);
    pulse(2*NSEC);
    rd_chk("R8 prim despite pmask", 2*NGRP, 8'h04);
    tick(2);
    pin_chk("R8 pin idle", 1, 1);
    wr(2, 8'h01);
    rd_chk("R8 prim clears", 2*NGRP, 8'h00);
  endtask

  task automatic t_prim_ro;
    wr(2*NGRP, 8'hFF);
    rd_chk("R6 prim", 2*NGRP, 8'h00);
    rd_chk("R6 pmask", 2*NGRP + 1, 8'h0D);
    rd_chk("R6 cfg", 2*NGRP + 2, 8'h00);
    tick();
    pin_chk("R6 pin", 1, 1);
  endtask

  task automatic t_collide;
    @(negedge clk);
    evt = '0; evt[1*NSEC + 3] = 1'b1;
    wr_en = 1; addr = AW'(1); wdata = 8'h08;
    @(negedge clk);
    evt = '0; wr_en = 0;
    rd_chk("R3 event wins", 1, 8'h08);
    wr(1, 8'h08);
    rd_chk("R3 later clear", 1, 8'h00);
    tick();
  endtask

  task automatic t_od;
    wr(2*NGRP + 2, 8'h02);
    tick();
    pin_chk("R9 released", 0, 0);
    pulse(1*NSEC + 3);
    tick();
    pin_chk("R9 drive low", 1, 0);
    wr(1, 8'h08);
    tick();
    pin_chk("R9 released again", 0, 0);
  endtask

  task automatic t_gmask;
    wr(2*NGRP + 2, 8'h01);
    pulse(1*NSEC + 3);
    tick(2);
    pin_chk("R10 pp inactive", 1, 1);
    rd_chk("R10 status latches", 1, 8'h08);
    wr(2*NGRP + 2, 8'h03);
    tick();
    pin_chk("R10 od released", 0, 0);
    wr(2*NGRP + 2, 8'h00);
    tick();
    pin_chk("R10 unmasked asserts", 1, 0);
    wr(1, 8'h08);
    tick();
    pin_chk("R10 final idle", 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_latch();
    t_w1c();
    t_masked();
    t_pmask();
    t_prim_ro();
    t_collide();
    t_od();
    t_gmask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule